// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block decides whether a 16550-style serial port should interrupt the host, and why. It holds the interrupt-enable register, a transmitter-empty pending flag and a sticky overrun flag. It combines these with a receive-data-present level and the modem-status delta bits, which come from neighbouring blocks. A fixed priority encoder picks one cause, and the block drives an interrupt line whenever that cause is anything other than "nothing pending".

The host reaches the block through a simple register port. Each access takes a single cycle, with an offset and a write or read strobe. Read data appears one clock after the strobe and holds until the next read. Three registers carry side effects: reading the identification register, reading the line-status register, and writing the data register. The FIFO storage, the modem-status register and the transmit shifter stay outside this block. When the divisor-latch access input is high, offsets 0 and 1 belong to the baud divisor, which also lives outside the block.

Top module: `uart_irq_ident`

## Requirements
- R1: Causes are ranked from highest to lowest as follows, each counting only when its enable bit is set:
  - overrun flag (enable bit 2), code 0x6;
  - receive data present (enable bit 0);
  - transmitter-empty pending (enable bit 1), code 0x2;
  - any modem delta bit (enable bit 3), code 0x0.
  With no qualified cause the code is 0x1.
- R2: Receive data present is reported with the character-timeout code 0xC.
- R3: A write to the data register (offset 0, divisor access low) sets the transmitter-empty pending flag.
- R4: A write to the enable register (offset 1, divisor access low) sets the pending flag only when it changes enable bit 1 from 0 to 1. Rewriting bit 1 while it is already 1 has no effect on the flag.
- R5: The enable register keeps only the written bits 3..0, and a read of it at offset 1 returns bits 7..4 as zero.
- R6: A read of the identification register (offset 2) clears the pending flag only when the code returned is 0x2. Otherwise the flag keeps its value.
- R7: The identification byte is {fifo_on, fifo_on, 2'b00, code}, so bits 7..6 are both set while the FIFO is enabled.
- R8: A pulse on the overrun input sets a sticky overrun flag. A read of the line-status register (offset 5) returns:
  - bit 6 = 1 and bit 5 = 1;
  - bit 1 = overrun flag;
  - bit 0 = receive data present;
  - all other bits 0.
  The same read clears the overrun flag, unless a new overrun arrives in that cycle.
- R9: The interrupt output is high exactly when the code is not 0x1. It reflects each access in the cycle after the access edge.
- R10: While divisor access is high, writes at offsets 0 and 1 change neither the enable register nor the pending flag, and a read at offset 1 returns 0x00.
- R11: Read data appears after the read edge and holds until the next read. Offsets the block does not decode read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| dlab | input | 1 | Divisor-latch access: offsets 0 and 1 go to the divisor |
| fifo_on | input | 1 | FIFO mode is enabled |
| rx_avail | input | 1 | At least one received character is waiting |
| ovr_in | input | 1 | One-cycle overrun event |
| msr_delta | input | 4 | Modem-status change bits |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets several corner cases, each of which a faulty design would get visibly wrong:
- Rewriting transmit enable while it is already 1. A level-sensitive design would re-arm the pending flag and report 0x2 again.
- Reading the identification register while receive data outranks the transmit cause. A design that cleared the flag on every such read would lose the transmit interrupt once the data is drained.
- Overrun with and without its enable. A design without the enable qualification would raise the line and report 0x6 where 0x1 is due.
- Two successive line-status reads. A design that failed to clear the flag would report bit 1 twice.
- Data and enable writes with divisor access high. Any leak would show as a changed enable read-back or a spurious 0x2.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned CODE_W = 4;

  // enable register bit positions
  localparam int unsigned IEN_RX    = 0;
  localparam int unsigned IEN_TX    = 1;
  localparam int unsigned IEN_LINE  = 2;
  localparam int unsigned IEN_MODEM = 3;

  // line status bit positions
  localparam int unsigned LSB_RXRDY = 0;
  localparam int unsigned LSB_OVR   = 1;
  localparam int unsigned LSB_THRE  = 5;
  localparam int unsigned LSB_TEMT  = 6;

  // register offsets
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IER  = 3'd1;
  localparam logic [2:0] OFS_IIR  = 3'd2;
  localparam logic [2:0] OFS_LSR  = 3'd5;

  typedef enum logic [CODE_W-1:0] {
    CAUSE_MODEM = 4'h0,
    CAUSE_NONE  = 4'h1,
    CAUSE_TXE   = 4'h2,
    CAUSE_LINE  = 4'h6,
    CAUSE_RXTO  = 4'hC
  } cause_e;
endpackage

// File: rtl/uart_irq_ier.sv
module uart_irq_ier
  import uart_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IER_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ier,
  input  logic [DATA_W-1:0] wdata,
  output logic [IER_W-1:0]  ier_q,
  output logic              tx_en_rise
);
  logic [IER_W-1:0] ier_d;

  always_comb begin
    ier_d      = ier_q;
    tx_en_rise = 1'b0;
    if (wr_ier) begin
      ier_d      = wdata[IER_W-1:0];
      tx_en_rise = ~ier_q[IEN_TX] & wdata[IEN_TX];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ier_q <= '0;
    else if (wr_ier) ier_q <= ier_d;
  end
endmodule

// File: rtl/uart_irq_flags.sv
module uart_irq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic txe_set,
  input  logic txe_clr,
  input  logic ovr_set,
  input  logic ovr_clr,
  output logic txe_q,
  output logic oe_q
);
  logic txe_d, oe_d, txe_ce, oe_ce;

  always_comb begin
    txe_ce = txe_set | txe_clr;
    oe_ce  = ovr_set | ovr_clr;
    // a set in the same cycle wins over a clear
    txe_d  = txe_set | (txe_q & ~txe_clr);
    oe_d   = ovr_set | (oe_q & ~ovr_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      if (txe_ce) txe_q <= txe_d;
      if (oe_ce)  oe_q  <= oe_d;
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int unsigned IER_W   = 4,
  parameter int unsigned DELTA_W = 4
) (
  input  logic [IER_W-1:0]   ier,
  input  logic               oe,
  input  logic               rx_avail,
  input  logic               txe,
  input  logic [DELTA_W-1:0] delta,
  output cause_e             cause
);
  logic want_line, want_rx, want_tx, want_modem;

  always_comb begin
    want_line  = oe       & ier[IEN_LINE];
    want_rx    = rx_avail & ier[IEN_RX];
    want_tx    = txe      & ier[IEN_TX];
    want_modem = (|delta) & ier[IEN_MODEM];
    if (want_line)       cause = CAUSE_LINE;
    else if (want_rx)    cause = CAUSE_RXTO;
    else if (want_tx)    cause = CAUSE_TXE;
    else if (want_modem) cause = CAUSE_MODEM;
    else                 cause = CAUSE_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DELTA_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               dlab,
  input  logic               fifo_on,
  input  logic               rx_avail,
  input  logic               ovr_in,
  input  logic [DELTA_W-1:0] msr_delta,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq
);
  localparam int unsigned IER_W = 4;
  localparam int unsigned PAD_W = DATA_W - 2 - CODE_W;

  logic              hit_data, hit_ier, hit_iir, hit_lsr;
  logic              wr_data, wr_ier, rd_iir, rd_lsr, rd_ier;
  logic [IER_W-1:0]  ier_q;
  logic              tx_en_rise, txe_q, oe_q;
  cause_e            cause;
  logic [DATA_W-1:0] iir_byte, lsr_byte, rdata_d;

  always_comb begin
    hit_data = (addr == ADDR_W'(OFS_DATA)) & ~dlab;
    hit_ier  = (addr == ADDR_W'(OFS_IER))  & ~dlab;
    hit_iir  = (addr == ADDR_W'(OFS_IIR));
    hit_lsr  = (addr == ADDR_W'(OFS_LSR));
    wr_data  = wr_en & hit_data;
    wr_ier   = wr_en & hit_ier;
    rd_iir   = rd_en & hit_iir;
    rd_lsr   = rd_en & hit_lsr;
    rd_ier   = rd_en & hit_ier;
  end

  uart_irq_ier #(.DATA_W(DATA_W), .IER_W(IER_W)) u_ier (
    .clk(clk), .rst_n(rst_n), .wr_ier(wr_ier), .wdata(wdata),
    .ier_q(ier_q), .tx_en_rise(tx_en_rise)
  );

  uart_irq_prio #(.IER_W(IER_W), .DELTA_W(DELTA_W)) u_prio (
    .ier(ier_q), .oe(oe_q), .rx_avail(rx_avail), .txe(txe_q),
    .delta(msr_delta), .cause(cause)
  );

  uart_irq_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .txe_set(wr_data | tx_en_rise),
    .txe_clr(rd_iir & (cause == CAUSE_TXE)),
    .ovr_set(ovr_in), .ovr_clr(rd_lsr),
    .txe_q(txe_q), .oe_q(oe_q)
  );

  always_comb begin
    iir_byte = {{2{fifo_on}}, {PAD_W{1'b0}}, cause};
    lsr_byte = '0;
    lsr_byte[LSB_TEMT]  = 1'b1;
    lsr_byte[LSB_THRE]  = 1'b1;
    lsr_byte[LSB_OVR]   = oe_q;
    lsr_byte[LSB_RXRDY] = rx_avail;
    if (rd_iir)      rdata_d = iir_byte;
    else if (rd_lsr) rdata_d = lsr_byte;
    else if (rd_ier) rdata_d = DATA_W'(ier_q);
    else             rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rdata_d;
  end

  assign irq = (cause != CAUSE_NONE);
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [2:0] addr,
  input logic       dlab,
  input logic       fifo_on,
  input logic       ovr_in,
  input logic [7:0] rdata,
  input logic       irq,
  input logic [3:0] ier_q,
  input logic       txe_q,
  input logic       oe_q
);
  // R1
  line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && ier_q[2]) |-> irq);

  // R3
  data_write_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && !dlab) |=> txe_q);

  // R5
  ier_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd1 && !dlab) |=> (rdata[7:4] == 4'h0));

  // R6
  iir_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd2 && !ier_q[1] && !wr_en) |=> (txe_q == $past(txe_q)));

  // R7
  fifo_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd2 && fifo_on) |=> (rdata[7:6] == 2'b11));

  // R8
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd5 && !ovr_in) |=> !oe_q);

  // R8
  lsr_tx_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd5) |=> (rdata[6:5] == 2'b11));
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .dlab(dlab), .fifo_on(fifo_on), .ovr_in(ovr_in), .rdata(rdata), .irq(irq),
  .ier_q(ier_q), .txe_q(txe_q), .oe_q(oe_q)
);

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
  logic       clk = 1'b0;
  logic       rst_n, wr_en, rd_en, dlab, fifo_on, rx_avail, ovr_in;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [3:0] msr_delta;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       mon_ev;

  always #2 clk = ~clk;

  uart_irq_ident u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .dlab(dlab), .fifo_on(fifo_on), .rx_avail(rx_avail),
    .ovr_in(ovr_in), .msr_delta(msr_delta), .rdata(rdata), .irq(irq)
  );

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
    exp_q.push_back(e);
    tag_q.push_back(t);
    ->mon_ev;
    #0;
  endtask

  task automatic pulse_ovr();
    @(negedge clk);
    ovr_in = 1'b1;
    @(posedge clk); #1;
    ovr_in = 1'b0;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] e, input string t);
    checks++;
    if (act !== e) begin
      failures++;
      $display("FAIL %s: actual=%02h expected=%02h", t, act, e);
    end
  endtask

  // monitor: compares each queued read result
  initial begin
    forever begin
      @(mon_ev);
      while (exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rdata, e, t);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; dlab = 1'b0; fifo_on = 1'b0;
    rx_avail = 1'b0; ovr_in = 1'b0; addr = '0; wdata = '0; msr_delta = '0;
    repeat (3) @(posedge clk);
    #1;
    chk({7'd0, irq}, 8'h00, "R9 reset irq");
    chk(rdata, 8'h00, "R11 reset rdata");
    @(negedge clk); rst_n = 1'b1;

    rd(3'd2, 8'h01, "R1 idle code");
    // R4: rising transmit enable arms the flag
    wr(3'd1, 8'hF2);
    chk({7'd0, irq}, 8'h01, "R4 rise arms irq");
    rd(3'd1, 8'h02, "R5 upper nibble zero");
    rd(3'd2, 8'h02, "R6 tx code");
    rd(3'd2, 8'h01, "R6 tx cleared by read");
    chk({7'd0, irq}, 8'h00, "R9 irq low");
    wr(3'd1, 8'h02);
    rd(3'd2, 8'h01, "R4 no rearm when already set");

    // R3 and R2 / R6 with receive data outranking
    wr(3'd0, 8'h55);
    chk({7'd0, irq}, 8'h01, "R3 data write arms");
    rx_avail = 1'b1;
    wr(3'd1, 8'h03);
    rd(3'd2, 8'h0C, "R2 rx timeout code");
    rx_avail = 1'b0;
    rd(3'd2, 8'h02, "R6 flag kept under rx");
    rd(3'd2, 8'h01, "R6 cleared");

    // R8 overrun
    wr(3'd1, 8'h07);
    rx_avail = 1'b1;
    pulse_ovr();
    rd(3'd2, 8'h06, "R1 line above rx");
    rd(3'd5, 8'h63, "R8 lsr with overrun");
    rd(3'd5, 8'h61, "R8 overrun cleared");
    rd(3'd2, 8'h0C, "R1 rx after overrun");
    rx_avail = 1'b0;

    wr(3'd1, 8'h03);
    pulse_ovr();
    chk({7'd0, irq}, 8'h00, "R1 line masked");
    rd(3'd2, 8'h01, "R1 masked code");
    rd(3'd5, 8'h62, "R8 lsr overrun only");

    // modem
    msr_delta = 4'b0100;
    #1;
    chk({7'd0, irq}, 8'h00, "R9 modem masked");
    wr(3'd1, 8'h08);
    rd(3'd2, 8'h00, "R1 modem code");
    chk({7'd0, irq}, 8'h01, "R9 modem irq");
    wr(3'd1, 8'h0A);
    rd(3'd2, 8'h02, "R1 tx above modem");
    rd(3'd2, 8'h00, "R6 back to modem");
    msr_delta = 4'b0000;
    #1;
    chk({7'd0, irq}, 8'h00, "R9 irq drops");

    fifo_on = 1'b1;
    rd(3'd2, 8'hC1, "R7 fifo bits");
    fifo_on = 1'b0;

    // R10 divisor access
    dlab = 1'b1;
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h11);
    rd(3'd1, 8'h00, "R10 divisor read at offset 1");
    dlab = 1'b0;
    rd(3'd1, 8'h0A, "R10 enable kept");
    rd(3'd2, 8'h01, "R10 no pending from data");

    rd(3'd3, 8'h00, "R11 undecoded offset");
    rd(3'd5, 8'h60, "R8 plain lsr");
    repeat (3) @(posedge clk);
    #1;
    chk(rdata, 8'h60, "R11 rdata holds");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule